// File: doc/BRIEF.md
# Serial EEPROM Device Emulator (SPI)

This block plays the device side of a small byte-wide serial EEPROM attached to an SPI host. A system clock that runs well above the serial clock oversamples the chip-select, serial clock, serial input, hold and write-protect pins. The block decodes the host's commands and drives the serial output. Storage is an 8192-byte inferred RAM. Page writes first collect in a 64-byte buffer. When chip select rises, the buffer is copied into the array during a timed internal write cycle, and the device reports itself busy for the whole of that cycle.

A command begins with an 8-bit opcode, sent MSB first. Array commands then carry a 16-bit address, of which only the low 13 bits are used. Data for the host changes on falling SCK edges, and the block samples input bits on rising edges. Both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) therefore work. The serial clock half-period must be at least 8 system clocks. The parameter `WR_CYCLES` must be at least the page size.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the write-enable latch is clear and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 shifts out the status byte, and repeats it for as long as clocking continues. The status byte is laid out as bit 7 = protect-enable, bits 3:2 = protect field, bit 1 = write-enable latch, bit 0 = busy, and all other bits 0.
- R3: While the write-enable latch is clear, a write (0x02) or a status write (0x01) has no effect on the array or on the status register.
- R4: Opcode 0x03 takes a 16-bit address, ignores its upper 3 bits, and returns array bytes MSB first. The address increments after each byte and wraps from 0x1FFF to 0x0000.
- R5: Write data bytes land at consecutive addresses that wrap inside the current 64-byte page, and a later byte overwrites an earlier one at the same address. Nothing is committed unless chip select rises after at least one whole data byte. If chip select rises after a partial byte, the array is unchanged and the latch stays set.
- R6: A commit makes status bit 0 read 1 for `WR_CYCLES` system clocks. At the end of that time the latch clears. While busy, every opcode except 0x05 is ignored.
- R7: A status write changes only bits 7, 3 and 2, and the new value appears at the end of its busy cycle.
- R8: A write is ignored while the protect field is nonzero. A status write is ignored while protect-enable is 1 and `wp_n` is low.
- R9: Transfers behave the same whether SCK idles low or high between commands.
- R10: A hold begins when `hold_n` falls while SCK is low, and ends when `hold_n` returns high. While a hold lasts, SCK and SI edges are ignored and the transfer resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write protect for the status register |
| so | output | 1 | Serial data to the host; 0 when deselected or held |

## Verification
The hardest case to reach from the pins is a command that arrives while a commit is still running. The bench uses a long `WR_CYCLES`, and starts a status read and then a write-disable immediately after the commit's chip-select rise. Both land inside the busy window, so the bench can see that the latch survived the disable. A hold is hard to reach cleanly as well. The bench stops SCK low in the middle of a read and in the middle of a write, pulses SCK and SI during the hold, and then checks that the data stream continues unbroken.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RD, PH_WR, PH_RSR, PH_WSR, PH_SKIP
  } phase_t;

  typedef enum logic {K_ARR, K_SR} kind_t;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_pgbuf.sv
module eep_pgbuf #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid
);
  localparam int PAGE = 1 << PW;
  logic [7:0]      ent [PAGE];
  logic [PAGE-1:0] mask;

  always_ff @(posedge clk) begin
    if (we) ent[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask <= '0;
    else if (clr) mask <= '0;
    else if (we)  mask[widx] <= 1'b1;
  end

  assign rdata  = ent[ridx];
  assign rvalid = mask[ridx];

  // R5
  clr_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && we));
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 6,
  parameter int WR_CYCLES   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int HI_W  = ADDR_W - 8;

  // pin synchronisers: {sck, cs_n, si, hold_n, wp_n}
  logic [4:0] pins_s;
  eep_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b01011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck, cs_n, si, hold_n, wp_n}), .q(pins_s)
  );
  logic sck_s, cs_s_n, si_s, hold_s_n, wp_s_n;
  assign {sck_s, cs_s_n, si_s, hold_s_n, wp_s_n} = pins_s;

  logic sck_d, cs_d, hold_q;
  logic sck_rise, sck_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_d & ~cs_s_n & ~hold_q;
  assign sck_fall = ~sck_s & sck_d & ~cs_s_n & ~hold_q;
  assign cs_rise  = cs_s_n & ~cs_d;

  // protocol state
  phase_t              phase;
  logic [2:0]          bit_cnt;
  logic [6:0]          sh;
  logic [7:0]          byte_in;
  logic                byte_done;
  logic                wr_op, any_byte, sr_ok;
  logic [ADDR_W-1:0]   addr;
  logic [ADDR_W-PAGE_W-1:0] wbase;
  logic [PAGE_W-1:0]   widx;
  logic                wel, wpen;
  logic [1:0]          bp;
  logic [7:0]          sr_new;
  logic                busy;
  kind_t               kind;
  logic [CNT_W-1:0]    bcnt;
  logic                so_q;
  logic [6:0]          osh;
  logic [7:0]          status;

  assign byte_in   = {sh, si_s};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign status    = {wpen, 3'b000, bp, wel, busy};

  // page buffer and array
  logic              pg_clr, pg_we, pg_valid;
  logic [7:0]        pg_rdata, ram_rd;
  logic [PAGE_W-1:0] pg_ridx;
  logic              ram_we;

  assign pg_clr  = byte_done && (phase == PH_ALO) && wr_op;
  assign pg_we   = byte_done && (phase == PH_WR);
  assign pg_ridx = bcnt[PAGE_W-1:0];
  assign ram_we  = busy && (kind == K_ARR) && (32'(bcnt) < PAGE) && pg_valid;

  eep_pgbuf #(.PW(PAGE_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .clr(pg_clr), .we(pg_we), .widx(widx),
    .wdata(byte_in), .ridx(pg_ridx), .rdata(pg_rdata), .rvalid(pg_valid)
  );

  eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr({wbase, pg_ridx}), .wdata(pg_rdata),
    .raddr(addr), .rdata(ram_rd)
  );

  // hold tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_q <= 1'b0;
    else if (cs_s_n)             hold_q <= 1'b0;
    else if (!hold_s_n && !sck_s) hold_q <= 1'b1;
    else if (hold_s_n)           hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1;
      phase <= PH_CMD; bit_cnt <= '0; sh <= '0;
      wr_op <= 1'b0; any_byte <= 1'b0; sr_ok <= 1'b0;
      addr <= '0; wbase <= '0; widx <= '0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; sr_new <= '0;
      busy <= 1'b0; kind <= K_ARR; bcnt <= '0;
      so_q <= 1'b0; osh <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s_n;

      // internal write cycle
      if (busy) begin
        if (bcnt == CNT_W'(WR_CYCLES - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (kind == K_SR) begin
            wpen <= sr_new[7];
            bp   <= sr_new[3:2];
          end
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end

      if (cs_s_n) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        so_q    <= 1'b0;
        if (cs_rise && (bit_cnt == 3'd0) && !busy) begin
          if (phase == PH_WR && any_byte) begin
            busy <= 1'b1; bcnt <= '0; kind <= K_ARR;
          end else if (phase == PH_SKIP && sr_ok) begin
            busy <= 1'b1; bcnt <= '0; kind <= K_SR;
          end
        end
      end else begin
        if (sck_rise) begin
          sh      <= {sh[5:0], si_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              sr_ok <= 1'b0;
              if (busy && byte_in != OP_RDSR) phase <= PH_SKIP;
              else begin
                case (byte_in)
                  OP_WREN: begin wel <= 1'b1; phase <= PH_SKIP; end
                  OP_WRDI: begin wel <= 1'b0; phase <= PH_SKIP; end
                  OP_RDSR: phase <= PH_RSR;
                  OP_READ: begin wr_op <= 1'b0; phase <= PH_AHI; end
                  OP_WRIT: begin
                    if (wel && bp == 2'b00) begin
                      wr_op <= 1'b1; phase <= PH_AHI;
                    end else phase <= PH_SKIP;
                  end
                  OP_WRSR: begin
                    if (wel && !(wpen && !wp_s_n)) phase <= PH_WSR;
                    else phase <= PH_SKIP;
                  end
                  default: phase <= PH_SKIP;
                endcase
              end
            end
            PH_AHI: begin
              addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
              phase <= PH_ALO;
            end
            PH_ALO: begin
              addr[7:0] <= byte_in;
              if (wr_op) begin
                wbase    <= {addr[ADDR_W-1:8], byte_in[7:PAGE_W]};
                widx     <= byte_in[PAGE_W-1:0];
                any_byte <= 1'b0;
                phase    <= PH_WR;
              end else begin
                phase <= PH_RD;
              end
            end
            PH_WR: begin
              widx     <= widx + 1'b1;
              any_byte <= 1'b1;
            end
            PH_WSR: begin
              sr_new <= byte_in;
              sr_ok  <= 1'b1;
              phase  <= PH_SKIP;
            end
            PH_SKIP: sr_ok <= 1'b0;
            default: ;
          endcase
        end

        // output shifter, advanced on falling SCK
        if (sck_fall && (phase == PH_RD || phase == PH_RSR)) begin
          if (bit_cnt == 3'd0) begin
            if (phase == PH_RD) begin
              so_q <= ram_rd[7];
              osh  <= ram_rd[6:0];
              addr <= addr + 1'b1;
            end else begin
              so_q <= status[7];
              osh  <= status[6:0];
            end
          end else begin
            so_q <= osh[6];
            osh  <= {osh[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign so = so_q & ~cs_s_n & ~hold_q;

  // R6
  busy_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(bcnt) < WR_CYCLES));
  // R6
  ram_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
  // R3
  commit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cs_s_n) |=> $stable(bit_cnt));
endmodule

// File: tb/sim_spi_eeprom_emu.sv
module sim_spi_eeprom_emu;
  localparam int H = 8;
  localparam int WRC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so;
  logic mode3 = 1'b0;
  int nvec = 0, nfail = 0;
  logic [7:0] mm [8192];

  always #2 clk = ~clk;

  spi_eeprom_emu #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i]; w(H);
      rx[i] = so; sck = 1'b1; w(H);
    end
  endtask

  task automatic xb(input logic [7:0] tx);
    logic [7:0] r;
    xbits(tx, 8, r);
  endtask

  task automatic cs_lo();
    sck = mode3; w(H); cs_n = 1'b0; w(H);
  endtask

  task automatic cs_hi();
    if (!mode3) begin sck = 1'b0; w(H); end
    cs_n = 1'b1; w(4*H);
  endtask

  task automatic do_hold();
    sck = 1'b0; w(H); hold_n = 1'b0; w(H);
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; w(H); si = 1'b0; sck = 1'b0; w(H);
    end
    hold_n = 1'b1; w(H);
  endtask

  task automatic op1(input logic [7:0] op);
    cs_lo(); xb(op); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo(); xb(8'h05); xbits(8'h00, 8, s); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); xb(8'h01); xb(v); cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] q[$]);
    cs_lo(); xb(8'h02); xb(a[15:8]); xb(a[7:0]);
    foreach (q[i]) xb(q[i]);
    cs_hi();
  endtask

  function automatic void mwrite(input logic [15:0] a, input logic [7:0] q[$]);
    logic [6:0] pg = a[12:6];
    logic [5:0] ix = a[5:0];
    foreach (q[i]) begin
      mm[{pg, ix}] = q[i];
      ix = ix + 1'b1;
    end
  endfunction

  task automatic rd_chk(input string req, input logic [15:0] a, input int n, input int hold_at);
    logic [7:0] r;
    logic [12:0] p = a[12:0];
    cs_lo(); xb(8'h03); xb(a[15:8]); xb(a[7:0]);
    for (int i = 0; i < n; i++) begin
      if (i == hold_at) do_hold();
      xbits(8'h00, 8, r);
      chk(req, r, mm[p]);
      p = p + 1'b1;
    end
    cs_hi();
  endtask

  task automatic wait_ready(input string req, input logic [7:0] exp);
    logic [7:0] s = 8'h01;
    for (int i = 0; i < 40 && s[0]; i++) rdsr(s);
    chk(req, s, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [7:0] q[$];
    for (int i = 0; i < 8192; i++) mm[i] = 8'h00;
    w(5); rst_n = 1'b1; w(5);

    // R1 reset state
    rdsr(s); chk("R1 status", s, 8'h00);
    rd_chk("R1 array", 16'h0000, 1, -1);

    // R3 write with latch clear
    q = {8'hAA}; wr(16'h0100, q);
    rdsr(s); chk("R3 status", s, 8'h00);
    rd_chk("R3 array", 16'h0100, 1, -1);

    // R2 latch set/clear
    op1(8'h06); rdsr(s); chk("R2 wren", s, 8'h02);
    op1(8'h04); rdsr(s); chk("R2 wrdi", s, 8'h00);

    // R5/R6 page wrap and busy window
    op1(8'h06);
    q = {8'h11, 8'h22, 8'h33}; wr(16'h003E, q); mwrite(16'h003E, q);
    rdsr(s); chk("R6 busy", s, 8'h03);
    op1(8'h04);
    rdsr(s); chk("R6 ignore during busy", s, 8'h03);
    wait_ready("R6 end clears latch", 8'h00);
    rd_chk("R5 page wrap", 16'h003E, 2, -1);
    rd_chk("R5 page wrap", 16'h0000, 1, -1);

    // R4 upper bits ignored and array wrap
    op1(8'h06);
    q = {8'h5A, 8'hA5}; wr(16'h1FFE, q); mwrite(16'h1FFE, q);
    wait_ready("R4 ready", 8'h00);
    rd_chk("R4 wrap", 16'hFFFE, 3, -1);

    // R5 overfull page
    op1(8'h06);
    q = {};
    for (int i = 0; i < 70; i++) q.push_back(8'((i * 3) + 1));
    wr(16'h0080, q); mwrite(16'h0080, q);
    wait_ready("R5 ready", 8'h00);
    rd_chk("R5 full page", 16'h0080, 64, -1);

    // R5 partial byte abort
    op1(8'h06);
    cs_lo(); xb(8'h02); xb(8'h00); xb(8'h40); xb(8'h77); xbits(8'hFF, 3, s); cs_hi();
    rdsr(s); chk("R5 partial status", s, 8'h02);
    rd_chk("R5 partial array", 16'h0040, 1, -1);
    op1(8'h04);

    // R7 status write masks
    op1(8'h06); wrsr(8'hFF);
    wait_ready("R7 wrsr", 8'h8C);

    // R8 protection
    op1(8'h06);
    q = {8'h55}; wr(16'h0200, q);
    rdsr(s); chk("R8 write blocked", s, 8'h8E);
    rd_chk("R8 array kept", 16'h0200, 1, -1);
    wp_n = 1'b0; wrsr(8'h00);
    rdsr(s); chk("R8 wrsr blocked", s, 8'h8E);
    wp_n = 1'b1; wrsr(8'h00);
    wait_ready("R8 wrsr allowed", 8'h00);

    // R9 SCK idling high
    mode3 = 1'b1;
    rd_chk("R9 mode3 read", 16'h0080, 4, -1);
    rdsr(s); chk("R9 mode3 status", s, 8'h00);
    mode3 = 1'b0;

    // R10 hold in write and read
    op1(8'h06);
    cs_lo(); xb(8'h02); xb(8'h05); xb(8'h00); xb(8'hC3); do_hold(); xb(8'h3C); cs_hi();
    q = {8'hC3, 8'h3C}; mwrite(16'h0500, q);
    wait_ready("R10 ready", 8'h00);
    rd_chk("R10 hold read", 16'h0500, 2, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule